// File: doc/BRIEF.md
# Low-Power Gating Control Register

This block is a single memory-mapped control word that sits in the always-on part of a bus-attached controller core. Four bits drive the core's low-power hooks: one withdraws the enable of the PHY clock, one withdraws the enable of the core clock to everything except the bus slave and master ports and the wakeup logic, one clamps the signals that cross into a switchable power domain, and one holds that domain in reset. The clock enables and domain controls are flops, so the downstream clock-gate cells and switches see clean levels.

The block also stands between the register bus and the rest of the core's registers. Accesses to any other address pass straight through to the core side. While the clamp or the domain reset is active, the block drives every signal that crosses into the core to zero, drops writes and returns zero on reads. The gating word itself remains reachable, so software can always recover by writing zero. Two build-time switches remove the core-clock gate bit and the partial power-down bits.

Top module: `pwr_gate_ctl`

## Requirements
- R1: After reset the control word reads 0, `phy_clk_en` and `core_clk_en` are 1, and `pd_clamp` and `pd_reset` are 0.
- R2: A write to `GATE_ADDR` loads bit 0. When bit 0 is 1, `phy_clk_en` is 0 from the clock edge that takes the write.
- R3: With `PWR_OPT_EN`=1, bit 1 set drives `core_clk_en` to 0. With `PWR_OPT_EN`=0, bit 1 reads 0, ignores writes, and `core_clk_en` stays 1.
- R4: With `PART_PD_EN`=1, bit 2 set drives `pd_clamp` to 1. While it is set, `core_rd`, `core_wr`, `core_addr` and `core_wdata` are all 0.
- R5: With `PART_PD_EN`=1, bit 3 set drives `pd_reset` to 1.
- R6: While `pd_clamp` or `pd_reset` is 1, a read of any address other than `GATE_ADDR` returns 0 and a write to such an address never reaches the core.
- R7: The gating word is readable and writable in every state. After 0xF is written, writing 0 restores pass-through, and reads of the core's ID register return its nonzero value again.
- R8: With `PART_PD_EN`=0, bits 2 and 3 are stored and read back but have no effect: `pd_clamp` and `pd_reset` stay 0 and accesses pass through.
- R9: The four control outputs change only at a clock edge that takes a write to `GATE_ADDR`. A write to any other address leaves them unchanged.
- R10: Read-data bits above bit 3 of the gating word read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from address |
| phy_clk_en | output | 1 | PHY clock enable (0 = stopped) |
| core_clk_en | output | 1 | Core clock enable for the gated modules (0 = gated) |
| pd_clamp | output | 1 | Clamp enable for the switchable-domain crossings |
| pd_reset | output | 1 | Reset to the switchable domain |
| core_rd | output | 1 | Read strobe to the core registers |
| core_wr | output | 1 | Write strobe to the core registers |
| core_addr | output | ADDR_W | Address to the core registers |
| core_wdata | output | DATA_W | Write data to the core registers |
| core_rdata | input | DATA_W | Read data from the core registers |

## Verification
The bench writes 0xF, the value that locks out the whole core, and confirms that the ID register reads 0 while the gating word still reads back 0xF. It then writes 0 and expects the nonzero ID to return. A design that isolated its own register would never leave that state. A scratch write issued under the clamp is read back after release to show it was dropped, because a leaking isolation would change the stored value. A second instance built without the optional bits checks that bit 1 reads 0 and that bits 2 and 3 leave the outputs and the pass-through alone. A design that ignored the build switches would gate the core clock or cut off the registers.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

  localparam int CTL_W = 4;

  // Bit order matters: software writes the word as a number.
  typedef struct packed {
    logic pd_rst;    // bit 3
    logic clamp;     // bit 2
    logic gate_bus;  // bit 1
    logic stop_phy;  // bit 0
  } pcg_ctl_t;

endpackage

// File: rtl/pcg_ctl_reg.sv
module pcg_ctl_reg
  import pcg_pkg::*;
#(
  parameter bit PWR_OPT_EN = 1'b1,
  parameter bit PART_PD_EN = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  pcg_ctl_t wr_val,
  output pcg_ctl_t ctl_q,
  output logic     phy_clk_en,
  output logic     core_clk_en,
  output logic     pd_clamp,
  output logic     pd_reset
);

  pcg_ctl_t ctl_d;
  logic     gate_bit;
  logic     clamp_d;
  logic     pdrst_d;

  generate
    if (PWR_OPT_EN) begin : g_gate_on
      assign gate_bit = wr_val.gate_bus;
    end else begin : g_gate_off
      assign gate_bit = 1'b0;
    end
  endgenerate

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) begin
      ctl_d          = wr_val;
      ctl_d.gate_bus = gate_bit;
    end
  end

  generate
    if (PART_PD_EN) begin : g_pd_on
      assign clamp_d = ctl_d.clamp;
      assign pdrst_d = ctl_d.pd_rst;
    end else begin : g_pd_off
      assign clamp_d = 1'b0;
      assign pdrst_d = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q       <= '0;
      phy_clk_en  <= 1'b1;
      core_clk_en <= 1'b1;
      pd_clamp    <= 1'b0;
      pd_reset    <= 1'b0;
    end else if (wr_en) begin
      ctl_q       <= ctl_d;
      phy_clk_en  <= ~ctl_d.stop_phy;
      core_clk_en <= ~ctl_d.gate_bus;
      pd_clamp    <= clamp_d;
      pd_reset    <= pdrst_d;
    end
  end

endmodule

// File: rtl/pcg_iso.sv
module pcg_iso
  import pcg_pkg::*;
#(
  parameter int              ADDR_W    = 12,
  parameter int              DATA_W    = 32,
  parameter logic [ADDR_W-1:0] GATE_ADDR = '0
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              iso,
  input  pcg_ctl_t          ctl_q,
  output logic              gate_wr,
  output logic              core_rd,
  output logic              core_wr,
  output logic [ADDR_W-1:0] core_addr,
  output logic [DATA_W-1:0] core_wdata,
  input  logic [DATA_W-1:0] core_rdata
);

  logic hit_gate;
  logic pass;

  assign hit_gate = (bus_addr == GATE_ADDR);
  assign pass     = ~iso;
  assign gate_wr  = bus_sel & bus_we & hit_gate;

  always_comb begin
    core_rd    = 1'b0;
    core_wr    = 1'b0;
    core_addr  = '0;
    core_wdata = '0;
    if (pass) begin
      core_rd    = bus_sel & ~bus_we & ~hit_gate;
      core_wr    = bus_sel &  bus_we & ~hit_gate;
      core_addr  = bus_addr;
      core_wdata = bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_gate) begin
      bus_rdata[CTL_W-1:0] = ctl_q;
    end else if (pass) begin
      bus_rdata = core_rdata;
    end
  end

endmodule

// File: rtl/pwr_gate_ctl.sv
module pwr_gate_ctl
  import pcg_pkg::*;
#(
  parameter int                ADDR_W     = 12,
  parameter int                DATA_W     = 32,
  parameter logic [ADDR_W-1:0] GATE_ADDR  = 12'hE00,
  parameter bit                PWR_OPT_EN = 1'b1,
  parameter bit                PART_PD_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              phy_clk_en,
  output logic              core_clk_en,
  output logic              pd_clamp,
  output logic              pd_reset,
  output logic              core_rd,
  output logic              core_wr,
  output logic [ADDR_W-1:0] core_addr,
  output logic [DATA_W-1:0] core_wdata,
  input  logic [DATA_W-1:0] core_rdata
);

  logic     rst_meta_n;
  logic     rst_sync_n;
  logic     gate_wr;
  logic     iso;
  pcg_ctl_t ctl_q;
  pcg_ctl_t wr_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign wr_val = pcg_ctl_t'(bus_wdata[CTL_W-1:0]);
  assign iso    = pd_clamp | pd_reset;

  pcg_ctl_reg #(
    .PWR_OPT_EN (PWR_OPT_EN),
    .PART_PD_EN (PART_PD_EN)
  ) u_reg (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_en       (gate_wr),
    .wr_val      (wr_val),
    .ctl_q       (ctl_q),
    .phy_clk_en  (phy_clk_en),
    .core_clk_en (core_clk_en),
    .pd_clamp    (pd_clamp),
    .pd_reset    (pd_reset)
  );

  pcg_iso #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .GATE_ADDR (GATE_ADDR)
  ) u_iso (
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .iso        (iso),
    .ctl_q      (ctl_q),
    .gate_wr    (gate_wr),
    .core_rd    (core_rd),
    .core_wr    (core_wr),
    .core_addr  (core_addr),
    .core_wdata (core_wdata),
    .core_rdata (core_rdata)
  );

endmodule

// File: rtl/pwr_gate_ctl_chk.sv
module pwr_gate_ctl_chk #(
  parameter int                ADDR_W     = 12,
  parameter int                DATA_W     = 32,
  parameter logic [ADDR_W-1:0] GATE_ADDR  = 12'hE00,
  parameter bit                PART_PD_EN = 1'b1
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              phy_clk_en,
  input logic              core_clk_en,
  input logic              pd_clamp,
  input logic              pd_reset,
  input logic              core_rd,
  input logic              core_wr,
  input logic [ADDR_W-1:0] core_addr,
  input logic [DATA_W-1:0] core_wdata
);

  logic gw;
  assign gw = bus_sel & bus_we & (bus_addr == GATE_ADDR);

  assert_phy_stop_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    gw |=> (phy_clk_en == !$past(bus_wdata[0])));

  assert_clamp_quiet_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pd_clamp |-> (!core_rd && !core_wr && core_addr == '0 && core_wdata == '0));

  assert_pd_reset_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (gw && PART_PD_EN) |=> (pd_reset == $past(bus_wdata[3])));

  assert_iso_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_sel && !bus_we && bus_addr != GATE_ADDR && (pd_clamp || pd_reset))
      |-> (bus_rdata == '0));

  assert_no_pd_effect_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !PART_PD_EN |-> (!pd_clamp && !pd_reset));

  assert_outputs_hold_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !gw |=> $stable({phy_clk_en, core_clk_en, pd_clamp, pd_reset}));

  assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_sel && !bus_we && bus_addr == GATE_ADDR) |-> (bus_rdata[DATA_W-1:4] == '0));

endmodule

bind pwr_gate_ctl pwr_gate_ctl_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .GATE_ADDR  (GATE_ADDR),
  .PART_PD_EN (PART_PD_EN)
) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .bus_sel     (bus_sel),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .phy_clk_en  (phy_clk_en),
  .core_clk_en (core_clk_en),
  .pd_clamp    (pd_clamp),
  .pd_reset    (pd_reset),
  .core_rd     (core_rd),
  .core_wr     (core_wr),
  .core_addr   (core_addr),
  .core_wdata  (core_wdata)
);

// File: tb/tb_pwr_gate_ctl.sv
module tb_pwr_gate_ctl;

  localparam int          AW       = 12;
  localparam int          DW       = 32;
  localparam logic [AW-1:0] GATE_A = 12'hE00;
  localparam logic [AW-1:0] ID_A   = 12'h040;
  localparam logic [AW-1:0] SCR_A  = 12'h010;
  localparam logic [DW-1:0] ID_VAL = 32'h4F54_2A0B;
  localparam int          NVEC     = 7;

  // {write value, phy_en, core_en, clamp, pd_reset, id_visible}
  localparam logic [8:0] VEC [NVEC] = '{
    {4'h0, 5'b11001}, {4'h1, 5'b01001}, {4'h2, 5'b10001}, {4'h4, 5'b11100},
    {4'h8, 5'b11010}, {4'hF, 5'b00110}, {4'h0, 5'b11001}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_sel, bus_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] rdata, m_rdata;
  logic          phy_en, core_en, clamp, pdrst;
  logic          m_phy_en, m_core_en, m_clamp, m_pdrst;
  logic          c_rd, c_wr, m_rd, m_wr;
  logic [AW-1:0] c_addr, m_addr;
  logic [DW-1:0] c_wdata, m_wdata, c_rdata, m_cdata;
  logic [DW-1:0] scratch;
  int            n_run = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  pwr_gate_ctl #(.ADDR_W(AW), .DATA_W(DW), .GATE_ADDR(GATE_A)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata),
    .phy_clk_en(phy_en), .core_clk_en(core_en), .pd_clamp(clamp), .pd_reset(pdrst),
    .core_rd(c_rd), .core_wr(c_wr), .core_addr(c_addr), .core_wdata(c_wdata),
    .core_rdata(c_rdata));

  pwr_gate_ctl #(.ADDR_W(AW), .DATA_W(DW), .GATE_ADDR(GATE_A),
                 .PWR_OPT_EN(1'b0), .PART_PD_EN(1'b0)) dut_min (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(m_rdata),
    .phy_clk_en(m_phy_en), .core_clk_en(m_core_en), .pd_clamp(m_clamp), .pd_reset(m_pdrst),
    .core_rd(m_rd), .core_wr(m_wr), .core_addr(m_addr), .core_wdata(m_wdata),
    .core_rdata(m_cdata));

  // Core register model: constant ID plus one scratch register.
  always_comb begin
    c_rdata = (c_addr == ID_A) ? ID_VAL : (c_addr == SCR_A) ? scratch : '0;
    m_cdata = (m_addr == ID_A) ? ID_VAL : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scratch <= 32'h0000_1111;
    else if (c_wr && c_addr == SCR_A) scratch <= c_wdata;
  end

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic [DW-1:0] dm);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    d = rdata; dm = m_rdata;
    bus_sel = 1'b0;
  endtask

  initial begin
    logic [DW-1:0] rd, rdm;
    logic [3:0]    wv;
    bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    bus_read(GATE_A, rd, rdm);
    check("R1 ctl", rd, 32'h0);
    check("R1 outs", {28'h0, phy_en, core_en, clamp, pdrst}, 32'hC);

    // Vector walk: each entry written, then outputs, readback and ID checked.
    for (int i = 0; i < NVEC; i++) begin
      wv = VEC[i][8:5];
      bus_write(GATE_A, {28'hABCDEF0, wv});
      check("R2 phy_clk_en", {31'h0, phy_en}, {31'h0, VEC[i][4]});
      check("R3 core_clk_en", {31'h0, core_en}, {31'h0, VEC[i][3]});
      check("R4 pd_clamp", {31'h0, clamp}, {31'h0, VEC[i][2]});
      check("R5 pd_reset", {31'h0, pdrst}, {31'h0, VEC[i][1]});
      bus_read(GATE_A, rd, rdm);
      check("R10 readback", rd, {28'h0, wv});
      check("R3 min readback", rdm, {28'h0, wv & 4'hD});
      check("R3 min core_clk_en", {31'h0, m_core_en}, 32'h1);
      check("R8 min pd outs", {30'h0, m_clamp, m_pdrst}, 32'h0);
      bus_read(ID_A, rd, rdm);
      check("R6 R7 id read", rd, VEC[i][0] ? ID_VAL : 32'h0);
      check("R8 min id read", rdm, ID_VAL);
    end

    // R6 blocked write is dropped; R7 recovery by writing 0.
    bus_write(GATE_A, 32'h4);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = SCR_A; bus_wdata = 32'hDEAD_0001;
    #1;
    check("R4 core_wr quiet", {31'h0, c_wr}, 32'h0);
    check("R4 core_wdata quiet", c_wdata, 32'h0);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    bus_write(GATE_A, 32'h8);
    bus_write(SCR_A, 32'hDEAD_0002);
    bus_write(GATE_A, 32'h0);
    bus_read(SCR_A, rd, rdm);
    check("R6 scratch kept", rd, 32'h0000_1111);
    bus_read(ID_A, rd, rdm);
    check("R7 id back", rd, ID_VAL);

    // R9 write to other register leaves outputs alone.
    bus_write(GATE_A, 32'h3);
    bus_write(SCR_A, 32'h0000_0000);
    check("R9 outs after other write", {28'h0, phy_en, core_en, clamp, pdrst}, 32'h0);
    bus_read(SCR_A, rd, rdm);
    check("R9 pass-through write", rd, 32'h0);
    bus_write(GATE_A, 32'h0);
    check("R9 outs restored", {28'h0, phy_en, core_en, clamp, pdrst}, 32'hC);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule